// File: doc/BRIEF.md
# Rectangular Window Write Engine

This block takes a stream of 16-bit host words and places them, in raster order, into a rectangle of a byte-addressed framebuffer. The host programs the rectangle's corners and a pixel format through a small write-only register port. It then pushes the pixel data through a data register.

A transfer starts, or arms, in one of two ways. Writing the source-select register arms it. So does the first data write while no transfer is pending. Arming checks the settings, latches the window, computes the row length and stride, and loads a word counter. Each accepted word writes its low byte and then its high byte into the framebuffer. When the counter empties, the transfer commits.

The block keeps a dirty rectangle for a downstream refresh engine. Each commit grows it to cover the finished window. A refresh handshake empties it. Changing the display enable or blank bit marks the whole panel dirty.

Top module: `window_write_engine`

## Requirements
- R1: Arming is refused, and a data word arriving with no pending transfer is dropped, when any of these holds: the source select is above 3, the format gives zero bytes per pixel, or an end coordinate is below its start coordinate. A refused arm from a source-select write leaves any pending transfer running unchanged.
- R2: The register select on `wr_addr` decodes as 0 X start, 1 Y start, 2 X end, 3 Y end, 4 format (data bits 3:0), 5 source select (bits 2:0, arms), 6 data port and 7 mode (bits 1:0). Format code 1 gives 2 bytes per pixel, codes 2 and 3 give 3, codes 6 and 7 give 4, and every other code gives 0.
- R3: An armed transfer takes floor(bpp*(xe-xs+1)*(ye-ys+1)/2) words. `busy` is high from the arm until the last word. `done` pulses for one cycle in the same cycle as the last word's framebuffer write, and `busy` is then low.
- R4: A data write with no pending transfer arms from the current registers, and that same word is the first word of the transfer.
- R5: A source-select write that passes the checks re-arms from the beginning, even during a pending transfer.
- R6: Byte n of the stream (row r = n div (bpp*width), column c) goes to ((ys+r)*PANEL_W + xs)*bpp + c. A word's low byte takes the next stream byte and its high byte the one after, so a word may straddle two rows. `fb_we`, both addresses and `fb_data` appear one cycle after the data write.
- R7: On commit, the dirty rectangle becomes the union of itself and the window latched at arm time, [xs, xe+1) by [ys, ye+1). Register changes made during the transfer do not affect it.
- R8: After reset, and one cycle after `refresh_done`, the dirty rectangle is empty: x0=PANEL_W, y0=PANEL_H, x1=0, y1=0. `refresh_req` is high when mode bit 0 is set and dirty x1 > dirty x0.
- R9: A mode write that changes bit 0 (enable) or bit 1 (blank) sets the dirty rectangle to the whole panel, (0,0)-(PANEL_W,PANEL_H). A write of the same value leaves it alone. `disp_en` and `disp_blank` show bits 0 and 1, and the downstream refresh sends zeros while `disp_blank` is high.
- R10: After reset the framebuffer port, `busy`, `done` and the mode bits are zero, the window is 0..0 and the format code is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 16 | Write data |
| refresh_done | input | 1 | Refresh pass finished, empty the dirty rectangle |
| fb_we | output | 1 | Framebuffer word write strobe |
| fb_addr_lo | output | 2*CW+2 | Byte address for fb_data[7:0] |
| fb_addr_hi | output | 2*CW+2 | Byte address for fb_data[15:8] |
| fb_data | output | 16 | Word to store |
| busy | output | 1 | Transfer pending |
| done | output | 1 | One-cycle commit pulse |
| disp_en | output | 1 | Display enable bit |
| disp_blank | output | 1 | Display blank bit |
| refresh_req | output | 1 | Dirty area present while enabled |
| dirty_x0 | output | CW+1 | Dirty rectangle left (inclusive) |
| dirty_y0 | output | CW+1 | Dirty rectangle top (inclusive) |
| dirty_x1 | output | CW+1 | Dirty rectangle right (exclusive) |
| dirty_y1 | output | CW+1 | Dirty rectangle bottom (exclusive) |

CW is the number of bits needed for the larger panel dimension.

## Verification
The bench builds the engine with a 12 by 10 panel. The stride is then not a power of two, and coordinates are four bits wide, so windows can reach past the right and bottom edges and push the dirty rectangle beyond the panel. Windows with 3 bytes per pixel and odd widths make words straddle rows. The small panel also lets full-edge windows and every format run in a few hundred cycles.

// File: rtl/window_write_engine.sv
module window_write_engine #(
  parameter int PANEL_W = 64,
  parameter int PANEL_H = 48
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [2:0]                    wr_addr,
  input  logic [15:0]                   wr_data,
  input  logic                          refresh_done,
  output logic                          fb_we,
  output logic [2*$clog2((PANEL_W > PANEL_H) ? PANEL_W : PANEL_H)+1:0] fb_addr_lo,
  output logic [2*$clog2((PANEL_W > PANEL_H) ? PANEL_W : PANEL_H)+1:0] fb_addr_hi,
  output logic [15:0]                   fb_data,
  output logic                          busy,
  output logic                          done,
  output logic                          disp_en,
  output logic                          disp_blank,
  output logic                          refresh_req,
  output logic [$clog2((PANEL_W > PANEL_H) ? PANEL_W : PANEL_H):0] dirty_x0,
  output logic [$clog2((PANEL_W > PANEL_H) ? PANEL_W : PANEL_H):0] dirty_y0,
  output logic [$clog2((PANEL_W > PANEL_H) ? PANEL_W : PANEL_H):0] dirty_x1,
  output logic [$clog2((PANEL_W > PANEL_H) ? PANEL_W : PANEL_H):0] dirty_y1
);
  localparam int CW = $clog2((PANEL_W > PANEL_H) ? PANEL_W : PANEL_H);
  localparam int DW = CW + 1;
  localparam int AW = 2 * CW + 2;
  localparam int LW = 2 * CW + 2;
  localparam int RW = CW + 3;

  localparam logic [2:0] A_XS = 3'd0, A_YS = 3'd1, A_XE = 3'd2, A_YE = 3'd3;
  localparam logic [2:0] A_FMT = 3'd4, A_SRC = 3'd5, A_DATA = 3'd6, A_MODE = 3'd7;

  logic [CW-1:0] xs_r, ys_r, xe_r, ye_r;
  logic [3:0]    fmt_r;
  logic [2:0]    src_r;
  logic [1:0]    mode_r;
  logic [LW-1:0] cnt_r;
  logic [RW-1:0] col_r, rb_r, stride_r;
  logic [AW-1:0] base_r;
  logic [CW-1:0] wx0_r, wy0_r;
  logic [DW-1:0] wx1_r, wy1_r;

  logic [2:0] bpp;
  always_comb begin
    case (fmt_r)
      4'd1:       bpp = 3'd2;
      4'd2, 4'd3: bpp = 3'd3;
      4'd6, 4'd7: bpp = 3'd4;
      default:    bpp = 3'd0;
    endcase
  end

  wire wr_src = wr_en && (wr_addr == A_SRC);
  wire wr_dat = wr_en && (wr_addr == A_DATA);
  wire wr_mode = wr_en && (wr_addr == A_MODE);
  wire [2:0] src_eff = wr_src ? wr_data[2:0] : src_r;

  wire arm_ok = (src_eff <= 3'd3) && (bpp != 3'd0) && (xe_r >= xs_r) && (ye_r >= ys_r);
  wire arm = arm_ok && (wr_src || (wr_dat && (cnt_r == '0)));
  wire accept = wr_dat && ((cnt_r != '0) || arm);

  wire [DW-1:0] w_n = DW'(xe_r) - DW'(xs_r) + DW'(1);
  wire [DW-1:0] h_n = DW'(ye_r) - DW'(ys_r) + DW'(1);
  wire [RW-1:0] rb_n = RW'(bpp) * RW'(w_n);
  wire [RW-1:0] stride_n = RW'(PANEL_W) * RW'(bpp);
  wire [AW-1:0] base_n = (AW'(ys_r) * AW'(PANEL_W) + AW'(xs_r)) * AW'(bpp);
  wire [LW:0]   bytes_n = (LW+1)'(rb_n) * (LW+1)'(h_n);
  wire [LW-1:0] words_n = LW'(bytes_n >> 1);

  wire [LW-1:0] cur_cnt = arm ? words_n : cnt_r;
  wire [RW-1:0] cur_col = arm ? '0 : col_r;
  wire [RW-1:0] cur_rb = arm ? rb_n : rb_r;
  wire [RW-1:0] cur_stride = arm ? stride_n : stride_r;
  wire [AW-1:0] cur_base = arm ? base_n : base_r;
  wire [CW-1:0] cur_wx0 = arm ? xs_r : wx0_r;
  wire [CW-1:0] cur_wy0 = arm ? ys_r : wy0_r;
  wire [DW-1:0] cur_wx1 = arm ? DW'(xe_r) + DW'(1) : wx1_r;
  wire [DW-1:0] cur_wy1 = arm ? DW'(ye_r) + DW'(1) : wy1_r;

  logic [RW-1:0] c1, c2;
  logic [AW-1:0] b1, b2;
  always_comb begin
    c1 = cur_col + RW'(1);
    b1 = cur_base;
    if (c1 == cur_rb) begin
      c1 = '0;
      b1 = cur_base + AW'(cur_stride);
    end
    c2 = c1 + RW'(1);
    b2 = b1;
    if (c2 == cur_rb) begin
      c2 = '0;
      b2 = b1 + AW'(cur_stride);
    end
  end

  wire last = accept && (cur_cnt == LW'(1));
  wire mode_chg = wr_mode && (wr_data[1:0] != mode_r);

  logic [DW-1:0] nx0, ny0, nx1, ny1;
  always_comb begin
    nx0 = dirty_x0; ny0 = dirty_y0; nx1 = dirty_x1; ny1 = dirty_y1;
    if (refresh_done) begin
      nx0 = DW'(PANEL_W); ny0 = DW'(PANEL_H); nx1 = '0; ny1 = '0;
    end
    if (last) begin
      if (DW'(cur_wx0) < nx0) nx0 = DW'(cur_wx0);
      if (DW'(cur_wy0) < ny0) ny0 = DW'(cur_wy0);
      if (cur_wx1 > nx1) nx1 = cur_wx1;
      if (cur_wy1 > ny1) ny1 = cur_wy1;
    end
    if (mode_chg) begin
      nx0 = '0; ny0 = '0; nx1 = DW'(PANEL_W); ny1 = DW'(PANEL_H);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs_r <= '0; ys_r <= '0; xe_r <= '0; ye_r <= '0;
      fmt_r <= 4'd3; src_r <= '0; mode_r <= '0;
      cnt_r <= '0; col_r <= '0; rb_r <= '0; stride_r <= '0; base_r <= '0;
      wx0_r <= '0; wy0_r <= '0; wx1_r <= '0; wy1_r <= '0;
      busy <= 1'b0; done <= 1'b0;
      fb_we <= 1'b0; fb_addr_lo <= '0; fb_addr_hi <= '0; fb_data <= '0;
      dirty_x0 <= DW'(PANEL_W); dirty_y0 <= DW'(PANEL_H);
      dirty_x1 <= '0; dirty_y1 <= '0;
    end else begin
      fb_we <= 1'b0;
      done <= 1'b0;
      dirty_x0 <= nx0; dirty_y0 <= ny0; dirty_x1 <= nx1; dirty_y1 <= ny1;
      if (wr_en) begin
        case (wr_addr)
          A_XS:    xs_r <= wr_data[CW-1:0];
          A_YS:    ys_r <= wr_data[CW-1:0];
          A_XE:    xe_r <= wr_data[CW-1:0];
          A_YE:    ye_r <= wr_data[CW-1:0];
          A_FMT:   fmt_r <= wr_data[3:0];
          A_SRC:   src_r <= wr_data[2:0];
          A_MODE:  mode_r <= wr_data[1:0];
          default: ;
        endcase
      end
      if (arm) begin
        cnt_r <= words_n; col_r <= '0; base_r <= base_n;
        rb_r <= rb_n; stride_r <= stride_n;
        wx0_r <= xs_r; wy0_r <= ys_r;
        wx1_r <= DW'(xe_r) + DW'(1); wy1_r <= DW'(ye_r) + DW'(1);
        busy <= 1'b1;
      end
      if (accept) begin
        fb_we <= 1'b1;
        fb_addr_lo <= cur_base + AW'(cur_col);
        fb_addr_hi <= b1 + AW'(c1);
        fb_data <= wr_data;
        col_r <= c2;
        base_r <= b2;
        cnt_r <= cur_cnt - LW'(1);
        if (cur_cnt == LW'(1)) begin
          done <= 1'b1;
          busy <= 1'b0;
        end
      end
    end
  end

  assign disp_en = mode_r[0];
  assign disp_blank = mode_r[1];
  assign refresh_req = mode_r[0] && (dirty_x1 > dirty_x0);

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_busy_ends_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_write_from_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> $past(wr_en && wr_addr == A_DATA));
  assert_refused_word_dropped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && cnt_r == '0 && !arm_ok) |=> !fb_we);
  assert_refresh_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_done && !wr_en) |=> (dirty_x1 == '0 && dirty_x0 == DW'(PANEL_W)));
  assert_mode_change_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && wr_data[1:0] != mode_r) |=>
      (dirty_x0 == '0 && dirty_y0 == '0 && dirty_x1 == DW'(PANEL_W) && dirty_y1 == DW'(PANEL_H)));
endmodule

// File: tb/sim_window_write_engine.sv
module sim_window_write_engine;
  localparam int PW = 12;
  localparam int PH = 10;
  localparam int CW = 4;
  localparam int AW = 2 * CW + 2;
  localparam int DW = CW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic refresh_done = 1'b0;
  logic fb_we, busy, done, disp_en, disp_blank, refresh_req;
  logic [AW-1:0] fb_addr_lo, fb_addr_hi;
  logic [15:0] fb_data;
  logic [DW-1:0] dirty_x0, dirty_y0, dirty_x1, dirty_y1;

  always #10 clk = ~clk;

  window_write_engine #(.PANEL_W(PW), .PANEL_H(PH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .refresh_done(refresh_done), .fb_we(fb_we), .fb_addr_lo(fb_addr_lo),
    .fb_addr_hi(fb_addr_hi), .fb_data(fb_data), .busy(busy), .done(done),
    .disp_en(disp_en), .disp_blank(disp_blank), .refresh_req(refresh_req),
    .dirty_x0(dirty_x0), .dirty_y0(dirty_y0), .dirty_x1(dirty_x1), .dirty_y1(dirty_y1));

  int total = 0;
  int bad = 0;
  int wcount = 0;
  bit finished = 0;

  int m_xs = 0, m_ys = 0, m_xe = 0, m_ye = 0, m_fmt = 3, m_src = 0, m_mode = 0;
  int m_cnt = 0, m_c = 0, m_base = 0, m_rb = 0, m_st = 0;
  int m_wx0 = 0, m_wy0 = 0, m_wx1 = 0, m_wy1 = 0;
  int m_busy = 0;
  int e_we = 0, e_lo = 0, e_hi = 0, e_data = 0, e_done = 0;
  int d_x0 = PW, d_y0 = PH, d_x1 = 0, d_y1 = 0;

  function automatic int bpp_of(int f);
    if (f == 1) return 2;
    if (f == 2 || f == 3) return 3;
    if (f == 6 || f == 7) return 4;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic adv_byte();
    m_c++;
    if (m_c == m_rb) begin
      m_c = 0;
      m_base += m_st;
    end
  endtask

  task automatic model(bit we, int a, int d, bit rd);
    int src_e, bv, w, h;
    bit ok, armv;
    e_we = 0;
    e_done = 0;
    if (rd) begin
      d_x0 = PW; d_y0 = PH; d_x1 = 0; d_y1 = 0;
    end
    src_e = (we && a == 5) ? (d & 7) : m_src;
    bv = bpp_of(m_fmt);
    ok = (src_e <= 3) && (bv != 0) && (m_xe >= m_xs) && (m_ye >= m_ys);
    armv = ok && we && (a == 5 || (a == 6 && m_cnt == 0));
    if (armv) begin
      w = m_xe - m_xs + 1;
      h = m_ye - m_ys + 1;
      m_rb = bv * w;
      m_st = PW * bv;
      m_base = (m_ys * PW + m_xs) * bv;
      m_c = 0;
      m_cnt = (m_rb * h) / 2;
      m_wx0 = m_xs; m_wy0 = m_ys; m_wx1 = m_xe + 1; m_wy1 = m_ye + 1;
      m_busy = 1;
    end
    if (we && a == 6 && m_cnt != 0) begin
      e_we = 1;
      e_data = d & 16'hffff;
      e_lo = m_base + m_c;
      adv_byte();
      e_hi = m_base + m_c;
      adv_byte();
      m_cnt--;
      if (m_cnt == 0) begin
        e_done = 1;
        m_busy = 0;
        if (m_wx0 < d_x0) d_x0 = m_wx0;
        if (m_wy0 < d_y0) d_y0 = m_wy0;
        if (m_wx1 > d_x1) d_x1 = m_wx1;
        if (m_wy1 > d_y1) d_y1 = m_wy1;
      end
    end
    if (we) begin
      case (a)
        0: m_xs = d & 15;
        1: m_ys = d & 15;
        2: m_xe = d & 15;
        3: m_ye = d & 15;
        4: m_fmt = d & 15;
        5: m_src = d & 7;
        7: begin
          if ((d & 3) != m_mode) begin
            d_x0 = 0; d_y0 = 0; d_x1 = PW; d_y1 = PH;
          end
          m_mode = d & 3;
        end
        default: ;
      endcase
    end
  endtask

  task automatic compare();
    chk("R6 fb_we", int'(fb_we), e_we);
    if (e_we != 0) begin
      chk("R6 fb_addr_lo", int'(fb_addr_lo), e_lo);
      chk("R6 fb_addr_hi", int'(fb_addr_hi), e_hi);
      chk("R6 fb_data", int'(fb_data), e_data);
    end
    if (fb_we) wcount++;
    chk("R3 busy", int'(busy), m_busy);
    chk("R3 done", int'(done), e_done);
    chk("R7 dirty_x0", int'(dirty_x0), d_x0);
    chk("R7 dirty_y0", int'(dirty_y0), d_y0);
    chk("R7 dirty_x1", int'(dirty_x1), d_x1);
    chk("R7 dirty_y1", int'(dirty_y1), d_y1);
    chk("R8 refresh_req", int'(refresh_req), int'((m_mode & 1) != 0 && d_x1 > d_x0));
    chk("R9 disp_en", int'(disp_en), m_mode & 1);
    chk("R9 disp_blank", int'(disp_blank), (m_mode >> 1) & 1);
  endtask

  task automatic tick(bit we, int a, int d, bit rd);
    wr_en = we;
    wr_addr = a[2:0];
    wr_data = d[15:0];
    refresh_done = rd;
    model(we, a, d, rd);
    @(negedge clk);
    compare();
    wr_en = 1'b0;
    refresh_done = 1'b0;
  endtask

  task automatic wreg(int a, int d);
    tick(1'b1, a, d, 1'b0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 0, 0, 1'b0);
  endtask

  task automatic win(int xs, int ys, int xe, int ye, int fmt);
    wreg(0, xs); wreg(1, ys); wreg(2, xe); wreg(3, ye); wreg(4, fmt);
  endtask

  task automatic push(int n, int seed);
    for (int i = 0; i < n; i++) wreg(6, (seed * 97 + i * 263) & 16'hffff);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 fb_we", int'(fb_we), 0);
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 disp", int'({disp_blank, disp_en}), 0);
    chk("R8 reset empty x0", int'(dirty_x0), PW);
    chk("R8 reset empty y0", int'(dirty_y0), PH);
    chk("R8 reset empty x1", int'(dirty_x1), 0);
    compare();

    // R4 R10: default window and format 3 -> one word, armed by the data write
    wcount = 0;
    wreg(6, 16'h1234);
    chk("R4 implicit arm words", wcount, 1);
    chk("R10 default addr hi", int'(fb_addr_hi), 1);
    idle(2);

    // R5 R2: format 1 (2 bytes), 3x2 window, armed by source select
    win(2, 1, 4, 2, 1);
    wreg(5, 0);
    chk("R5 busy after arm", int'(busy), 1);
    wcount = 0;
    push(6, 1);
    chk("R2 fmt1 words", wcount, 6);
    idle(1);

    // R6 R2: format 2 (3 bytes), odd width, words straddle rows
    win(1, 3, 3, 4, 2);
    wcount = 0;
    push(9, 2);
    chk("R6 straddle words", wcount, 9);

    // R2: format 7 (4 bytes) at the panel edge
    win(9, 8, 11, 9, 7);
    wcount = 0;
    push(12, 3);
    chk("R2 fmt7 words", wcount, 12);

    // R2: format 6 and format 3 single column
    win(0, 0, 0, 3, 6);
    push(8, 4);
    win(5, 5, 5, 6, 3);
    push(3, 5);

    // R1: refused arms drop words
    win(0, 0, 1, 1, 1);
    wreg(5, 4);
    chk("R1 no arm src>3", int'(busy), 0);
    wcount = 0;
    push(3, 6);
    chk("R1 src>3 dropped", wcount, 0);
    wreg(5, 3);
    push(4, 7);
    win(0, 0, 1, 1, 0);
    wcount = 0;
    push(2, 8);
    chk("R1 bpp0 dropped", wcount, 0);
    win(3, 0, 2, 1, 1);
    push(2, 9);
    win(0, 3, 1, 2, 1);
    push(2, 10);
    chk("R1 end<start dropped", wcount, 0);

    // R1: refused source-select write keeps the pending transfer
    win(0, 0, 1, 1, 1);
    wreg(5, 1);
    push(2, 11);
    wreg(5, 6);
    chk("R1 pending kept busy", int'(busy), 1);
    wcount = 0;
    push(2, 12);
    chk("R1 pending completes", wcount, 2);

    // R5: restart during a pending transfer
    win(4, 4, 7, 5, 7);
    wreg(5, 0);
    push(5, 13);
    wreg(5, 2);
    wcount = 0;
    push(16, 14);
    chk("R5 restart full count", wcount, 16);

    // R7: window changes mid-transfer do not move the commit
    win(6, 2, 7, 3, 1);
    wreg(5, 0);
    push(2, 15);
    wreg(0, 0); wreg(2, 15); wreg(3, 9);
    push(2, 16);
    chk("R7 latched x1", int'(dirty_x1) >= 8, 1);

    // R8: refresh empties, R9 mode changes
    tick(1'b0, 0, 0, 1'b1);
    chk("R8 empty after refresh", int'(dirty_x1), 0);
    wreg(7, 1);
    chk("R9 full on enable", int'(dirty_x1), PW);
    chk("R8 req when enabled", int'(refresh_req), 1);
    tick(1'b0, 0, 0, 1'b1);
    chk("R8 no req when empty", int'(refresh_req), 0);
    wreg(7, 1);
    chk("R9 same value no change", int'(dirty_x1), 0);
    wreg(7, 3);
    chk("R9 blank toggles full", int'(dirty_y1), PH);
    tick(1'b0, 0, 0, 1'b1);

    // R7: window past the panel edge widens the dirty area beyond it
    win(13, 1, 15, 1, 1);
    push(3, 17);
    chk("R7 beyond edge x1", int'(dirty_x1), 16);
    win(1, 0, 2, 0, 1);
    push(2, 18);
    chk("R7 union x0", int'(dirty_x0), 1);
    wreg(7, 0);
    idle(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule